// File: doc/BRIEF.md
# Dataflow Operand Matching Processing Element

This block is one processing element of a tiled dataflow machine. It has no program counter. Instructions sit in a small set of numbered slots, and each slot fires as soon as all the operands it needs have arrived. Operand tokens come from two places. One is a network port with valid/ready flow control. The other is an internal loop-back path that carries results the element addresses to itself.

Every accepted token passes through five stages. The input stage picks a token source. The match stage writes the operand into the matching table and, when the slot becomes complete, pushes the slot number (never the operands) into a ready FIFO. The dispatch stage pops a slot number, reads that slot's operands and clears its presence bits. The execute stage applies the slot's ALU operation. The output stage sends the result to each configured destination in turn, one token per cycle.

A configuration port loads each slot's opcode and destination list before tokens are sent.

Top module: `operand_match_pe`

## Requirements
- R1: After reset, `netReady` is 1, `outValid` is 0, and no output token appears while no tokens are sent.
- R2: A configuration write stores the opcode, the destination count (0 to 2) and two destinations. A destination word is packed as bit 5 = remote flag (1 = network, 0 = local loop-back), bits 4:1 = target slot, bit 0 = operand select.
- R3: Opcodes are add=0, sub=1, and=2, or=3, xor=4, pass=5. Codes 0 to 4 fire only when both operands are present. The result is operand0 OP operand1, and sub computes operand0 minus operand1 modulo 2^32.
- R4: A pass slot (code 5) fires on operand0 alone and forwards it unchanged.
- R5: A destination with remote flag 0 re-enters the element as an operand token and never appears on the output port.
- R6: When a loop-back token is pending, it is taken ahead of the network. `netReady` is 0 for that cycle, and the network token is held and accepted later without loss.
- R7: A token addressed to an operand that is already present is stalled, not written, until the slot has been dispatched. Both values then fire in arrival order.
- R8: A slot with two destinations emits to destination 0 and then destination 1. When both are remote, the two tokens appear on consecutive cycles.
- R9: Ready slots are dispatched in the order they became ready. The ready FIFO holds `QUEUE_DEPTH` entries, a slot is never queued twice, dispatch happens only from a non-empty queue, and matching stalls while the queue is full.
- R10: Dispatch clears the slot's presence bits, so the same slot can fire again on a fresh set of operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSlot | input | 4 | Slot being configured |
| cfgOp | input | 3 | Opcode for the slot |
| cfgDestCnt | input | 2 | Number of destinations, 0 to 2 |
| cfgDest0 | input | 6 | First destination {remote, slot, select} |
| cfgDest1 | input | 6 | Second destination {remote, slot, select} |
| netValid | input | 1 | Network token valid |
| netReady | output | 1 | Element accepts the network token this cycle |
| netSlot | input | 4 | Target slot of the network token |
| netSel | input | 1 | Operand select of the network token |
| netData | input | 32 | Operand value |
| outValid | output | 1 | A remote result token is on the output this cycle |
| outSlot | output | 4 | Consumer slot of the output token |
| outSel | output | 1 | Consumer operand select |
| outData | output | 32 | Result value |

## Verification
The bench sends a second token to an operand that is still present. A design that overwrites instead of stalling loses a firing or fires the wrong value. It raises a loop-back token and a network token in the same cycle. A design with the wrong priority, or one that drops the held token, reorders or loses an output. It also checks that single-operand add does not fire early, that sub produces the right sign and wrap-around, that two-destination slots emit in order on back-to-back cycles, and that a long burst of ready slots leaves in arrival order. A FIFO with broken pointers would scramble or duplicate slots in that burst.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int SLOT_W = 4;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_PASS = 3'd5
  } peOp_e;

  typedef struct packed {
    logic              remote;
    logic [SLOT_W-1:0] slot;
    logic              sel;
  } peDest_t;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              sel;
    logic [DATA_W-1:0] data;
  } peMsg_t;

  // datapath -> control
  typedef struct packed {
    logic              conflict;
    logic              becomesReady;
    logic [SLOT_W-1:0] inSlot;
    logic [1:0]        destCnt;
    logic              curLocal;
  } peStatus_t;

  // control -> datapath
  typedef struct packed {
    logic              takeLocal;
    logic              takeNet;
    logic              matchTake;
    logic              pop;
    logic [SLOT_W-1:0] popSlot;
    logic              moveEx;
    logic              emitLocal;
  } peStrobe_t;
endpackage

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  peStrobe_t         strb,
  input  logic              outIdx,
  output peStatus_t         stat,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [2:0]        cfgOp,
  input  logic [1:0]        cfgDestCnt,
  input  peDest_t           cfgDest0,
  input  peDest_t           cfgDest1,
  input  peMsg_t            netMsg,
  output logic [SLOT_W-1:0] emitSlot,
  output logic              emitSel,
  output logic [DATA_W-1:0] emitData
);
  logic [2:0]        opTab   [SLOTS];
  logic [1:0]        cntTab  [SLOTS];
  peDest_t           destTab [SLOTS][2];
  logic [1:0]        pres    [SLOTS];
  logic [1:0]        presNext[SLOTS];
  logic [DATA_W-1:0] opnd    [SLOTS][2];

  peMsg_t            inMsg, localMsg;
  logic [DATA_W-1:0] exA, exB, resReg;
  logic [2:0]        exOp;
  logic [SLOT_W-1:0] exSlot, resSlot;
  logic [1:0]        inPres, inMask;
  logic [2:0]        inOp;
  peDest_t           curDest;

  function automatic logic fires(input logic [2:0] op, input logic [1:0] p);
    return (op <= 3'd4) ? (p[0] & p[1]) : p[0];
  endfunction

  function automatic logic [DATA_W-1:0] alu(input logic [2:0] op,
                                            input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return a;
    endcase
  endfunction

  // match-stage decode of the token in the input register
  always_comb begin
    inPres            = pres[inMsg.slot];
    inOp              = opTab[inMsg.slot];
    inMask            = inMsg.sel ? 2'b10 : 2'b01;
    stat.conflict     = |(inPres & inMask);
    stat.becomesReady = !fires(inOp, inPres) && fires(inOp, inPres | inMask);
    stat.inSlot       = inMsg.slot;
    stat.destCnt      = cntTab[resSlot];
    curDest           = destTab[resSlot][outIdx];
    stat.curLocal     = !curDest.remote;
  end

  assign emitSlot = curDest.slot;
  assign emitSel  = curDest.sel;
  assign emitData = resReg;

  // presence: dispatch clears first, an accepted token then sets its bit
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      presNext[i] = pres[i];
      if (strb.pop && strb.popSlot == SLOT_W'(i)) presNext[i] = 2'b00;
      if (strb.matchTake && inMsg.slot == SLOT_W'(i)) presNext[i] = presNext[i] | inMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        pres[i]       <= 2'b00;
        opTab[i]      <= OP_PASS;
        cntTab[i]     <= 2'd0;
        destTab[i][0] <= '0;
        destTab[i][1] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) pres[i] <= presNext[i];
      if (cfgWe) begin
        opTab[cfgSlot]      <= cfgOp;
        cntTab[cfgSlot]     <= cfgDestCnt;
        destTab[cfgSlot][0] <= cfgDest0;
        destTab[cfgSlot][1] <= cfgDest1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.matchTake) opnd[inMsg.slot][inMsg.sel] <= inMsg.data;
  end

  // pipeline registers: input, loop-back, execute, output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMsg    <= '0;
      localMsg <= '0;
      exA      <= '0;
      exB      <= '0;
      exOp     <= '0;
      exSlot   <= '0;
      resReg   <= '0;
      resSlot  <= '0;
    end else begin
      if (strb.takeLocal)    inMsg <= localMsg;
      else if (strb.takeNet) inMsg <= netMsg;
      if (strb.emitLocal) localMsg <= '{slot: curDest.slot, sel: curDest.sel, data: resReg};
      if (strb.pop) begin
        exA    <= opnd[strb.popSlot][0];
        exB    <= opnd[strb.popSlot][1];
        exOp   <= opTab[strb.popSlot];
        exSlot <= strb.popSlot;
      end
      if (strb.moveEx) begin
        resReg  <= alu(exOp, exA, exB);
        resSlot <= exSlot;
      end
    end
  end
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int QUEUE_DEPTH = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               netValid,
  output logic                               netReady,
  input  peStatus_t                          stat,
  output peStrobe_t                          strb,
  output logic                               outIdx,
  output logic                               remoteEmit,
  output logic                               localPending,
  output logic                               qPush,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0]   qCount
);
  localparam int QW = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CW = $clog2(QUEUE_DEPTH + 1);

  logic              inValid, localValid, exValid, outValid;
  logic [SLOT_W-1:0] qMem [QUEUE_DEPTH];
  logic [QW-1:0]     rdPtr, wrPtr;
  logic [CW-1:0]     count;

  logic canEmit, lastDest, emitNow, outDone, outFree, moveEx, exFree;
  logic pop, room, matchTake, inFree, takeLocal, takeNet;

  function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
    return (p == QW'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    canEmit   = (stat.destCnt == 2'd0) || !stat.curLocal || !localValid;
    lastDest  = outIdx || (stat.destCnt <= 2'd1);
    emitNow   = outValid && (stat.destCnt != 2'd0) && canEmit;
    outDone   = outValid && canEmit && lastDest;
    outFree   = !outValid || outDone;
    moveEx    = exValid && outFree;
    exFree    = !exValid || moveEx;
    pop       = (count != '0) && exFree;
    room      = (count < CW'(QUEUE_DEPTH)) || pop;
    matchTake = inValid && !stat.conflict && (!stat.becomesReady || room);
    qPush     = matchTake && stat.becomesReady;
    inFree    = !inValid || matchTake;
    takeLocal = localValid && inFree;
    takeNet   = netValid && inFree && !localValid;
  end

  assign netReady     = inFree && !localValid;
  assign remoteEmit   = emitNow && !stat.curLocal;
  assign localPending = localValid;
  assign qCount       = count;

  assign strb.takeLocal = takeLocal;
  assign strb.takeNet   = takeNet;
  assign strb.matchTake = matchTake;
  assign strb.pop       = pop;
  assign strb.popSlot   = qMem[rdPtr];
  assign strb.moveEx    = moveEx;
  assign strb.emitLocal = emitNow && stat.curLocal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inValid    <= 1'b0;
      localValid <= 1'b0;
      exValid    <= 1'b0;
      outValid   <= 1'b0;
      outIdx     <= 1'b0;
      rdPtr      <= '0;
      wrPtr      <= '0;
      count      <= '0;
    end else begin
      inValid    <= takeLocal || takeNet || (inValid && !matchTake);
      localValid <= (emitNow && stat.curLocal) || (localValid && !takeLocal);
      exValid    <= pop || (exValid && !moveEx);
      outValid   <= moveEx || (outValid && !outDone);
      if (moveEx)       outIdx <= 1'b0;
      else if (emitNow) outIdx <= 1'b1;
      if (qPush) wrPtr <= bump(wrPtr);
      if (pop)   rdPtr <= bump(rdPtr);
      case ({qPush, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (qPush) qMem[wrPtr] <= stat.inSlot;
  end
endmodule

// File: rtl/operand_match_pe.sv
module operand_match_pe
  import pe_pkg::*;
#(
  parameter int QUEUE_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [2:0]        cfgOp,
  input  logic [1:0]        cfgDestCnt,
  input  logic [SLOT_W+1:0] cfgDest0,
  input  logic [SLOT_W+1:0] cfgDest1,
  input  logic              netValid,
  output logic              netReady,
  input  logic [SLOT_W-1:0] netSlot,
  input  logic              netSel,
  input  logic [DATA_W-1:0] netData,
  output logic              outValid,
  output logic [SLOT_W-1:0] outSlot,
  output logic              outSel,
  output logic [DATA_W-1:0] outData
);
  localparam int CW = $clog2(QUEUE_DEPTH + 1);

  peStrobe_t     strb;
  peStatus_t     stat;
  logic          outIdx, localPending, qPush;
  logic [CW-1:0] qCount;

  pe_ctrl #(.QUEUE_DEPTH(QUEUE_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .netValid(netValid), .netReady(netReady),
    .stat(stat), .strb(strb), .outIdx(outIdx), .remoteEmit(outValid),
    .localPending(localPending), .qPush(qPush), .qCount(qCount)
  );

  pe_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .outIdx(outIdx), .stat(stat),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgOp(cfgOp), .cfgDestCnt(cfgDestCnt),
    .cfgDest0(peDest_t'(cfgDest0)), .cfgDest1(peDest_t'(cfgDest1)),
    .netMsg('{slot: netSlot, sel: netSel, data: netData}),
    .emitSlot(outSlot), .emitSel(outSel), .emitData(outData)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker
  import pe_pkg::*;
#(
  parameter int QUEUE_DEPTH = 8
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             netReady,
  input logic                             localPending,
  input logic                             pushEn,
  input logic [SLOT_W-1:0]                pushSlot,
  input logic                             popEn,
  input logic [SLOT_W-1:0]                popSlot,
  input logic [$clog2(QUEUE_DEPTH+1)-1:0] qCount
);
  localparam int CW = $clog2(QUEUE_DEPTH + 1);

  // independent record of which slots sit in the ready queue
  logic [SLOTS-1:0] qMask;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qMask <= '0;
    else qMask <= (qMask & ~(popEn ? (SLOTS'(1) << popSlot) : '0))
                | (pushEn ? (SLOTS'(1) << pushSlot) : '0);
  end

  assert_local_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    localPending |-> !netReady);

  assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CW'(QUEUE_DEPTH));

  assert_single_enqueue_R9: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> !qMask[pushSlot]);

  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> (qCount != '0));

  assert_pop_was_queued_R9: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> qMask[popSlot]);

  assert_full_blocks_push_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn) |-> (qCount < CW'(QUEUE_DEPTH)));
endmodule

bind operand_match_pe pe_checker #(.QUEUE_DEPTH(QUEUE_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .netReady(netReady), .localPending(localPending),
  .pushEn(qPush), .pushSlot(stat.inSlot), .popEn(strb.pop),
  .popSlot(strb.popSlot), .qCount(qCount)
);

// File: tb/operand_match_pe_tb.sv
module operand_match_pe_tb;
  import pe_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgSlot = '0;
  logic [2:0]  cfgOp = '0;
  logic [1:0]  cfgDestCnt = '0;
  logic [5:0]  cfgDest0 = '0, cfgDest1 = '0;
  logic        netValid = 1'b0;
  logic        netReady;
  logic [3:0]  netSlot = '0;
  logic        netSel = 1'b0;
  logic [31:0] netData = '0;
  logic        outValid;
  logic [3:0]  outSlot;
  logic        outSel;
  logic [31:0] outData;

  always #10 clk = ~clk;

  operand_match_pe u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgOp(cfgOp),
    .cfgDestCnt(cfgDestCnt), .cfgDest0(cfgDest0), .cfgDest1(cfgDest1),
    .netValid(netValid), .netReady(netReady), .netSlot(netSlot), .netSel(netSel),
    .netData(netData), .outValid(outValid), .outSlot(outSlot), .outSel(outSel),
    .outData(outData)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int capN    = 0;
  logic [3:0]  capSlot [256];
  logic        capSel  [256];
  logic [31:0] capData [256];
  int          capCyc  [256];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN && outValid && capN < 256) begin
      capSlot[capN] = outSlot;
      capSel[capN]  = outSel;
      capData[capN] = outData;
      capCyc[capN]  = cyc;
      capN = capN + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  function automatic logic [5:0] rdest(input logic [3:0] s, input logic sel);
    return {1'b1, s, sel};
  endfunction
  function automatic logic [5:0] ldest(input logic [3:0] s, input logic sel);
    return {1'b0, s, sel};
  endfunction

  // all tasks start and end at a falling edge
  task automatic cfg(input logic [3:0] s, input logic [2:0] op, input logic [1:0] cnt,
                     input logic [5:0] d0, input logic [5:0] d1);
    cfgWe = 1'b1; cfgSlot = s; cfgOp = op; cfgDestCnt = cnt; cfgDest0 = d0; cfgDest1 = d1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic send(input logic [3:0] s, input logic sel, input logic [31:0] d);
    bit acc;
    int guard = 0;
    netValid = 1'b1; netSlot = s; netSel = sel; netData = d;
    do begin
      acc = netReady;
      @(negedge clk);
      guard++;
    end while (!acc && guard < 500);
    netValid = 1'b0;
  endtask

  task automatic waitOut(input int target);
    for (int i = 0; i < 300 && capN < target; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(input int idx, input logic [3:0] s, input logic sel,
                           input logic [31:0] d, input string tag);
    check(capN > idx, {tag, " token present"}, capN, idx + 1);
    if (capN > idx) begin
      check({capSlot[idx], capSel[idx]} == {s, sel}, {tag, " address"},
            {capSlot[idx], capSel[idx]}, {s, sel});
      check(capData[idx] == d, {tag, " data"}, capData[idx], d);
    end
  endtask

  task automatic testReset();
    check(netReady == 1'b1, "R1 netReady after reset", netReady, 1);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    idle(10);
    check(capN == 0, "R1 no output while idle", capN, 0);
  endtask

  task automatic testAlu();
    logic [2:0]  ops [6] = '{OP_ADD, OP_SUB, OP_SUB, OP_AND, OP_OR, OP_XOR};
    logic [31:0] as  [6] = '{32'd10, 32'd10, 32'd3, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0};
    logic [31:0] bs  [6] = '{32'd3, 32'd3, 32'd10, 32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00};
    logic [31:0] ex  [6] = '{32'd13, 32'd7, 32'hFFFFFFF9, 32'hF000F000, 32'hFFF0FFF0, 32'h0FF00FF0};
    for (int k = 0; k < 6; k++) begin
      int base = capN;
      cfg(4'd0, ops[k], 2'd1, rdest(4'd5, 1'b1), 6'd0);
      send(4'd0, 1'b0, as[k]);
      if (k == 0) begin
        idle(20);
        check(capN == base, "R3 two-operand op waits for operand1", capN, base);
      end
      send(4'd0, 1'b1, bs[k]);
      waitOut(base + 1);
      expectOut(base, 4'd5, 1'b1, ex[k], "R3 R2 alu result");
    end
  endtask

  task automatic testPass();
    int base = capN;
    cfg(4'd6, OP_PASS, 2'd1, rdest(4'd9, 1'b0), 6'd0);
    send(4'd6, 1'b0, 32'h0000ABCD);
    waitOut(base + 1);
    expectOut(base, 4'd9, 1'b0, 32'h0000ABCD, "R4 pass on operand0 alone");
  endtask

  task automatic testChain();
    int base = capN;
    cfg(4'd1, OP_ADD, 2'd1, ldest(4'd2, 1'b0), 6'd0);
    cfg(4'd2, OP_PASS, 2'd1, rdest(4'd3, 1'b1), 6'd0);
    send(4'd1, 1'b0, 32'd100);
    send(4'd1, 1'b1, 32'd23);
    waitOut(base + 1);
    idle(20);
    check(capN == base + 1, "R5 local destination stays internal", capN, base + 1);
    expectOut(base, 4'd3, 1'b1, 32'd123, "R5 loop-back chain");
  endtask

  task automatic testDuplicate();
    int base = capN;
    cfg(4'd4, OP_PASS, 2'd1, rdest(4'd4, 1'b0), 6'd0);
    send(4'd4, 1'b0, 32'd7);
    send(4'd4, 1'b0, 32'd9);
    waitOut(base + 2);
    idle(20);
    check(capN == base + 2, "R7 R10 duplicate operand fires twice", capN, base + 2);
    expectOut(base,     4'd4, 1'b0, 32'd7, "R7 first value kept");
    expectOut(base + 1, 4'd4, 1'b0, 32'd9, "R10 slot refires on new operand");
  endtask

  task automatic testTwoDest();
    int base = capN;
    cfg(4'd11, OP_XOR, 2'd2, rdest(4'd12, 1'b0), rdest(4'd13, 1'b1));
    send(4'd11, 1'b0, 32'h12345678);
    send(4'd11, 1'b1, 32'h0000FFFF);
    waitOut(base + 2);
    expectOut(base,     4'd12, 1'b0, 32'h1234A987, "R8 destination 0 first");
    expectOut(base + 1, 4'd13, 1'b1, 32'h1234A987, "R8 destination 1 second");
    if (capN >= base + 2)
      check(capCyc[base + 1] - capCyc[base] == 1, "R8 consecutive cycles",
            capCyc[base + 1] - capCyc[base], 1);
  endtask

  task automatic testPriority();
    int base = capN;
    bit sawLow = 0;
    bit acc;
    int guard = 0;
    cfg(4'd7, OP_PASS, 2'd1, ldest(4'd8, 1'b0), 6'd0);
    cfg(4'd8, OP_PASS, 2'd1, rdest(4'd1, 1'b0), 6'd0);
    cfg(4'd9, OP_PASS, 2'd1, rdest(4'd2, 1'b0), 6'd0);
    send(4'd7, 1'b0, 32'h77);
    for (int i = 0; i < 50; i++) begin
      if (!netReady) begin sawLow = 1; break; end
      @(negedge clk);
    end
    check(sawLow, "R6 netReady drops while loop-back pending", sawLow, 1);
    netValid = 1'b1; netSlot = 4'd9; netSel = 1'b0; netData = 32'h99;
    check(netReady == 1'b0, "R6 network held in collision cycle", netReady, 0);
    do begin
      acc = netReady;
      @(negedge clk);
      guard++;
    end while (!acc && guard < 500);
    netValid = 1'b0;
    waitOut(base + 2);
    expectOut(base,     4'd1, 1'b0, 32'h77, "R6 loop-back token first");
    expectOut(base + 1, 4'd2, 1'b0, 32'h99, "R6 held network token delivered");
  endtask

  task automatic testBurst();
    int base = capN;
    logic [3:0] order [12] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
                               4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
    for (int k = 0; k < 12; k++)
      cfg(order[k], OP_PASS, 2'd2, rdest(order[k], 1'b0), rdest(order[k], 1'b1));
    for (int k = 0; k < 12; k++)
      send(order[k], 1'b0, 32'h100 + 32'(k));
    waitOut(base + 24);
    for (int k = 0; k < 12; k++) begin
      expectOut(base + 2*k,     order[k], 1'b0, 32'h100 + 32'(k), "R9 dispatch order d0");
      expectOut(base + 2*k + 1, order[k], 1'b1, 32'h100 + 32'(k), "R9 dispatch order d1");
    end
    idle(20);
    check(capN == base + 24, "R9 no slot fired twice", capN, base + 24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAlu();
    testPass();
    testChain();
    testDuplicate();
    testTwoDest();
    testPriority();
    testBurst();
    idle(5);
    summary();
    $finish;
  end
endmodule